// File: doc/BRIEF.md
# Transmit Stall Watchdog Monitor

This block watches a transmit path on a periodic tick and decides whether the path has stopped moving. On every tick it compares four live counters against snapshots taken at the previous tick. The four counters are transmitted frames, received pause frames, the MAC start-of-packet count and the upstream drop count. The comparisons are made in a fixed order of precedence, and the block ends each tick with a fresh set of snapshots.

When a stall is found, the block asks the surrounding logic to briefly disable and re-enable transmit. If stalls keep recurring, an escalation counter grows, and once it passes its limit the block asks for a full MAC reset instead. Both requests are single-cycle pulses. A 2-bit status code reports the outcome of the most recent tick. Carrying out either request is left to the surrounding logic.

Top module: `stall_wd_mon`

## Requirements
- R1: While `rst_ni` is low, `status_o` is 0 and neither request output is asserted.
- R2: On a tick where the frame count or the pause count differs from its snapshot, status is 0 (code 0 = healthy) and the escalation counter is cleared.
- R3: On a tick with no frame or pause change and a nonzero start-of-packet count, status is 0 and no request is issued, even if the drop count moved.
- R4: A stall is declared only on a tick with no frame or pause change, a zero start-of-packet count, a drop count that differs from its snapshot, and a start-of-packet snapshot that was zero at the previous tick.
- R5: A stall with the escalation counter at ESC_LIMIT (default 4) or below gives status 1 (code 1 = toggle), pulses `toggle_req_o` and increments the counter, so the first five stalls in a row each give a toggle.
- R6: A stall with the escalation counter above ESC_LIMIT gives status 2 (code 2 = reset), pulses `reset_req_o` and clears the counter, so the next stall is again a toggle.
- R7: On a tick that samples the drop count but finds no stall, status is 0 and the escalation counter is cleared.
- R8: After a tick that did not look at the start-of-packet count, because the frame or pause count changed, the start-of-packet snapshot counts as nonzero, so the next tick cannot stall.
- R9: While `enable_i` is low, ticks are ignored, status is 0, the escalation counter is held at zero and all snapshots follow the live counters. The first enabled tick compares against the values present just before enabling.
- R10: Requests appear in the cycle after the tick, last one cycle unless the next cycle is also a tick, and are never both high. Between ticks, `status_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Monitoring enable; low loads snapshots |
| tick_i | input | 1 | Evaluation strobe |
| tx_frames_i | input | CNT_W | Live transmitted-frame count |
| rx_pause_i | input | CNT_W | Live received-pause count |
| sop_cnt_i | input | CNT_W | Live MAC start-of-packet count |
| drop_cnt_i | input | CNT_W | Live upstream drop count |
| status_o | output | 2 | Result of last tick: 0 healthy, 1 toggle, 2 reset |
| toggle_req_o | output | 1 | Transmit disable/re-enable request pulse |
| reset_req_o | output | 1 | Full MAC reset request pulse |

## Verification
Two things can coincide in one cycle: the request pulse from one tick, and the evaluation of the next tick in consecutive cycles. Together they exercise the escalation counter's increment, its limit and its clear in adjacent cycles. The bench re-enables monitoring and then issues six ticks with no gap, each showing a fresh drop count. Every tick's expected code and pulse are queued separately, so five toggles must appear on five consecutive cycles followed by one reset pulse. A leftover count from before the disable, or a pulse that fails to drop or merge, shows up as a mismatch on a specific tick.

// File: rtl/stall_wd_pkg.sv
package stall_wd_pkg;
  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_TOGGLE = 2'd1,
    ST_RESET  = 2'd2
  } wd_status_e;
endpackage

// File: rtl/stall_wd_snap.sv
module stall_wd_snap #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] cnt_i,
  output logic         changed_o
);
  logic [W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     snap_q <= '0;
    else if (load_i) snap_q <= cnt_i;
  end

  assign changed_o = (cnt_i != snap_q);
endmodule

// File: rtl/stall_wd_decide.sv
module stall_wd_decide
  import stall_wd_pkg::*;
#(
  parameter int ESC_LIMIT = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       tick_i,
  input  logic       progress_i,
  input  logic       sop_nz_i,
  input  logic       drop_chg_i,
  output logic       sample_drop_o,
  output wd_status_e status_o,
  output logic       toggle_req_o,
  output logic       reset_req_o
);
  localparam int ESC_W = $clog2(ESC_LIMIT + 2);
  localparam logic [ESC_W-1:0] ESC_MAX = ESC_W'(ESC_LIMIT);

  logic             fire;
  logic [ESC_W-1:0] esc_q, esc_d;
  logic             sop_zero_q, sop_zero_d;
  wd_status_e       status_q, status_d;
  logic             tog_d, rst_d, smp_drop;

  assign fire = tick_i & enable_i;

  always_comb begin
    status_d   = ST_OK;
    esc_d      = esc_q;
    sop_zero_d = sop_zero_q;
    tog_d      = 1'b0;
    rst_d      = 1'b0;
    smp_drop   = 1'b0;
    if (progress_i) begin
      esc_d      = '0;
      sop_zero_d = 1'b0;  // unsampled start-of-packet counts as nonzero
    end else if (sop_nz_i) begin
      sop_zero_d = 1'b0;
    end else begin
      smp_drop   = 1'b1;
      sop_zero_d = 1'b1;
      if (drop_chg_i && sop_zero_q) begin
        if (esc_q <= ESC_MAX) begin
          status_d = ST_TOGGLE;
          tog_d    = 1'b1;
          esc_d    = esc_q + 1'b1;
        end else begin
          status_d = ST_RESET;
          rst_d    = 1'b1;
          esc_d    = '0;
        end
      end else begin
        esc_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      esc_q        <= '0;
      sop_zero_q   <= 1'b0;
      status_q     <= ST_OK;
      toggle_req_o <= 1'b0;
      reset_req_o  <= 1'b0;
    end else if (!enable_i) begin
      esc_q        <= '0;
      sop_zero_q   <= ~sop_nz_i;
      status_q     <= ST_OK;
      toggle_req_o <= 1'b0;
      reset_req_o  <= 1'b0;
    end else if (fire) begin
      esc_q        <= esc_d;
      sop_zero_q   <= sop_zero_d;
      status_q     <= status_d;
      toggle_req_o <= tog_d;
      reset_req_o  <= rst_d;
    end else begin
      toggle_req_o <= 1'b0;
      reset_req_o  <= 1'b0;
    end
  end

  assign status_o      = status_q;
  assign sample_drop_o = smp_drop;

  AST_ESC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    esc_q <= ESC_MAX + 1'b1);  // R5
  AST_RESET_PAST_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> ($past(esc_q) > ESC_MAX));  // R6
  AST_RESET_CLEARS_ESC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> (esc_q == '0));  // R6
  AST_PULSE_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (toggle_req_o || reset_req_o) |-> $past(tick_i && enable_i));  // R10
  AST_ONE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(toggle_req_o && reset_req_o));  // R10
  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && !tick_i) |=> $stable(status_q));  // R10
endmodule

// File: rtl/stall_wd_mon.sv
module stall_wd_mon
  import stall_wd_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int ESC_LIMIT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] tx_frames_i,
  input  logic [CNT_W-1:0] rx_pause_i,
  input  logic [CNT_W-1:0] sop_cnt_i,
  input  logic [CNT_W-1:0] drop_cnt_i,
  output logic [1:0]       status_o,
  output logic             toggle_req_o,
  output logic             reset_req_o
);
  localparam int NUM_PROG = 2;

  logic                 fire, prog_load, drop_load, sample_drop, drop_chg, progress;
  logic [CNT_W-1:0]     prog_cnt [NUM_PROG];
  logic [NUM_PROG-1:0]  prog_chg;
  wd_status_e           status;

  assign fire        = tick_i & enable_i;
  assign prog_load   = ~enable_i | fire;
  assign drop_load   = ~enable_i | (fire & sample_drop);
  assign prog_cnt[0] = tx_frames_i;
  assign prog_cnt[1] = rx_pause_i;
  assign progress    = |prog_chg;

  for (genvar g = 0; g < NUM_PROG; g++) begin : g_prog
    stall_wd_snap #(.W(CNT_W)) u_snap (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (prog_load),
      .cnt_i     (prog_cnt[g]),
      .changed_o (prog_chg[g])
    );
  end

  stall_wd_snap #(.W(CNT_W)) u_drop_snap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (drop_load),
    .cnt_i     (drop_cnt_i),
    .changed_o (drop_chg)
  );

  stall_wd_decide #(.ESC_LIMIT(ESC_LIMIT)) u_decide (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .enable_i      (enable_i),
    .tick_i        (tick_i),
    .progress_i    (progress),
    .sop_nz_i      (|sop_cnt_i),
    .drop_chg_i    (drop_chg),
    .sample_drop_o (sample_drop),
    .status_o      (status),
    .toggle_req_o  (toggle_req_o),
    .reset_req_o   (reset_req_o)
  );

  assign status_o = status;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (status_o == 2'd0 && !toggle_req_o && !reset_req_o));  // R9
  AST_TOGGLE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    toggle_req_o |-> (status_o == 2'd1));  // R5
  AST_RESET_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> (status_o == 2'd2));  // R6
  AST_PROGRESS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && progress) |=> (status_o == 2'd0 && !toggle_req_o && !reset_req_o));  // R2
endmodule

// File: tb/stall_wd_mon_bench.sv
module stall_wd_mon_bench;
  logic        clk = 1'b0;
  logic        rst_n, enable, tick;
  logic [31:0] frames, pause, sop, drop;
  logic [1:0]  status;
  logic        tog, rreq;

  int n_cmp = 0, n_bad = 0;
  logic        fire_d = 1'b0, en_d = 1'b0, started = 1'b0, done = 1'b0;
  logic [1:0]  last_st = 2'd0;
  logic [1:0]  exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;  // 125 MHz

  stall_wd_mon u_stall_wd_mon (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .tick_i(tick),
    .tx_frames_i(frames), .rx_pause_i(pause), .sop_cnt_i(sop), .drop_cnt_i(drop),
    .status_o(status), .toggle_req_o(tog), .reset_req_o(rreq)
  );

  task automatic check(input logic ok, input string tag, input logic [1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: status=%0d toggle=%0b reset=%0b expected status=%0d toggle=%0b reset=%0b",
               tag, status, tog, rreq, exp, exp == 2'd1, exp == 2'd2);
    end
  endtask

  always @(posedge clk) begin
    fire_d <= tick && enable && rst_n;
    en_d   <= enable && rst_n;
  end

  // monitor: compare each tick's result against the queued expectation
  always @(negedge clk) begin
    if (started && rst_n) begin
      if (fire_d) begin
        if (exp_q.size() == 0) check(1'b0, "R10 unexpected tick", 2'd0);
        else begin
          logic [1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(status == e && tog == (e == 2'd1) && rreq == (e == 2'd2), t, e);
          last_st = e;
        end
      end else if (!en_d) begin
        check(status == 2'd0 && !tog && !rreq, "R9 idle", 2'd0);
        last_st = 2'd0;
      end else begin
        check(status == last_st && !tog && !rreq, "R10 hold", last_st);
      end
    end
  end

  task automatic tick_at(input logic [31:0] f, p, s, d, input logic [1:0] e, input string t);
    frames = f; pause = p; sop = s; drop = d;
    tick = 1'b1;
    if (enable) begin
      exp_q.push_back(e);
      tag_q.push_back(t);
    end
    @(negedge clk);
  endtask

  task automatic idle();
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; tick = 1'b0;
    frames = 32'd10; pause = 32'd3; sop = 32'd5; drop = 32'd100;
    repeat (3) @(negedge clk);
    check(status == 2'd0 && !tog && !rreq, "R1", 2'd0);
    rst_n = 1'b1;
    @(negedge clk);
    started = 1'b1;
    enable = 1'b1;
    idle();

    tick_at(11, 3, 5, 100, 2'd0, "R2 frame moved"); idle();
    tick_at(11, 3, 0, 101, 2'd0, "R8 sop unsampled"); idle();
    tick_at(11, 3, 0, 102, 2'd1, "R5 first toggle"); idle();
    tick_at(11, 3, 0, 103, 2'd1, "R5 second toggle"); idle();
    tick_at(11, 3, 0, 103, 2'd0, "R7 drop steady"); idle();
    tick_at(11, 3, 0, 104, 2'd1, "R4 stall after clear"); idle();
    tick_at(11, 3, 0, 105, 2'd1, "R4 stall again"); idle();
    tick_at(11, 4, 0, 106, 2'd0, "R2 pause moved"); idle();
    tick_at(11, 4, 0, 107, 2'd0, "R8 after pause"); idle();
    for (int i = 0; i < 5; i++) begin
      tick_at(11, 4, 0, 108 + i, 2'd1, "R5 toggle run"); idle();
    end
    tick_at(11, 4, 0, 113, 2'd2, "R6 escalate to reset"); idle();
    tick_at(11, 4, 0, 114, 2'd1, "R6 counter cleared"); idle();
    tick_at(11, 4, 3, 115, 2'd0, "R3 sop nonzero"); idle();

    enable = 1'b0;
    idle(); idle();
    tick_at(50, 9, 0, 200, 2'd0, "R9 ignored"); idle();
    enable = 1'b1;
    idle();
    for (int i = 0; i < 5; i++) tick_at(50, 9, 0, 201 + i, 2'd1, "R9 reload toggle");
    tick_at(50, 9, 0, 206, 2'd2, "R10 back-to-back reset");
    idle();
    tick_at(51, 9, 0, 207, 2'd0, "R2 after reset"); idle();
    repeat (3) idle();

    if (exp_q.size() != 0) check(1'b0, "R10 missing results", 2'd0);
    finish_run();
  end
endmodule